// File: doc/BRIEF.md
# CAN Receive Status Flag Register

This block holds eight sticky status flags for a CAN receiver and an eight-bit interrupt mask beside them. Each flag is driven by a level condition input from logic outside the block: wake-up detection, error-counter thresholds, bus-off state, receive overrun and a full receive buffer. A flag is set while its condition is high and stays set after the condition goes away, until software clears it.

Software clears a flag by writing a 1 to its bit. Unlike a plain write-one-to-clear register, the clear is dropped if the condition behind the flag is still active in the write cycle. Software then has to write the 1 again once the condition has ended. A single interrupt line is the OR of all flags whose mask bit is 1. The flags can be cleared by an asynchronous hard reset or by a synchronous soft clear. The mask keeps its value through a soft clear.

Top module: `can_rx_flag_reg`

## Requirements
- R1: Condition input bit k sets flag bit k. The flags are, from bit 7 down to bit 0: wake-up, receive warning, transmit warning, receive error-passive, transmit error-passive, bus-off, overrun and receive-buffer-full.
- R2: A flag whose condition is high at a clock edge reads 1 after that edge and stays 1 after the condition falls.
- R3: A write with `sel_i`=0 and bit k of `wdata_i` at 1 clears flag k at that edge if condition k is low.
- R4: A flag bit written with 0 keeps its value.
- R5: A clear write to a flag is ignored while its condition is high, including a condition that rises in the same cycle as the write. The flag then stays set after the condition ends, until a new write of 1.
- R6: A write with `sel_i`=1 loads the interrupt mask from `wdata_i`. A read with `sel_i`=1 returns the mask, and a read with `sel_i`=0 returns the flags. Mask bit positions match flag bit positions.
- R7: `irq_o` is 1 exactly when some flag bit and the mask bit at the same position are both 1.
- R8: `soft_clr_i` high at an edge clears all flags, overriding any active condition. It leaves the mask unchanged.
- R9: `rst_n_i` low clears the flags and the mask at once, without waiting for a clock edge.
- R10: Reads have no side effect. Reading either register repeatedly returns the same value when no write, condition or clear happens in between.

Port widths below are for the default parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Hard reset, active low. Asserts asynchronously and is released synchronously. |
| soft_clr_i | input | 1 | Synchronous clear of all flags |
| cond_i | input | 8 | Condition levels, one per flag |
| wr_en_i | input | 1 | Write strobe |
| sel_i | input | 1 | Register select: 0 selects the flags, 1 selects the mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The clear path is tried with three patterns:
- condition low, which tells a working clear apart from a stuck flag;
- condition still high, which tells a conditional clear apart from a plain write-one-to-clear;
- condition rising in the write cycle, which tells set priority apart from clear priority.

Each write mixes ones and zeros in `wdata_i`, so a clear that reaches an unselected bit is exposed. Mask writes made while flags are already set show whether the interrupt follows the mask or only the flags. A soft clear issued with a condition active, followed by a mask read, separates soft-clear priority and mask retention from a full reset.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;
  localparam int unsigned FLAG_W = 8;

  // Flag positions, highest bit first
  localparam int unsigned FB_WAKE    = 7;
  localparam int unsigned FB_RX_WARN = 6;
  localparam int unsigned FB_TX_WARN = 5;
  localparam int unsigned FB_RX_PASV = 4;
  localparam int unsigned FB_TX_PASV = 3;
  localparam int unsigned FB_BUS_OFF = 2;
  localparam int unsigned FB_OVERRUN = 1;
  localparam int unsigned FB_RX_FULL = 0;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/can_flag_bit.sv
module can_flag_bit (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic soft_clr_i,
  input  logic cond_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Priority: soft clear, then the condition, then the write clear
  always_comb begin
    flag_d  = flag_q;
    flag_en = 1'b0;
    if (soft_clr_i) begin
      flag_d  = 1'b0;
      flag_en = 1'b1;
    end else if (cond_i) begin
      flag_d  = 1'b1;
      flag_en = 1'b1;
    end else if (clr_req_i) begin
      flag_d  = 1'b0;
      flag_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_flag_enable.sv
module can_flag_enable #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] en_d;

  always_comb begin
    en_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q <= '0;
    end else if (load_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/can_flag_irq.sv
module can_flag_irq #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] masked;

  always_comb begin
    masked = flags_i & en_i;
    irq_o  = |masked;
  end
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import can_flag_pkg::*;
#(
  parameter int unsigned NFLAG = FLAG_W
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             soft_clr_i,
  input  logic [NFLAG-1:0] cond_i,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic [NFLAG-1:0] wdata_i,
  output logic [NFLAG-1:0] rdata_o,
  output logic             irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  logic [NFLAG-1:0]       clr_req;
  logic [NFLAG-1:0]       flag_q;
  logic [NFLAG-1:0]       en_q;
  logic                   en_load;
  reg_sel_e               sel;

  // Reset asserts asynchronously; release is synchronised to clk_i
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    sel     = reg_sel_e'(sel_i);
    clr_req = (wr_en_i && sel == SEL_FLAGS) ? wdata_i : '0;
    en_load = wr_en_i && sel == SEL_ENABLE;
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    can_flag_bit u_bit (
      .clk_i     (clk_i),
      .rst_n_i   (rst_sync_n),
      .soft_clr_i(soft_clr_i),
      .cond_i    (cond_i[gi]),
      .clr_req_i (clr_req[gi]),
      .flag_o    (flag_q[gi])
    );
  end

  can_flag_enable #(.WIDTH(NFLAG)) u_enable (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .load_i (en_load),
    .data_i (wdata_i),
    .en_o   (en_q)
  );

  can_flag_irq #(.WIDTH(NFLAG)) u_irq (
    .flags_i(flag_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = (sel == SEL_ENABLE) ? en_q : flag_q;
  end
endmodule

// File: rtl/can_rx_flag_reg_chk.sv
module can_rx_flag_reg_chk #(
  parameter int unsigned NFLAG = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             soft_clr_i,
  input logic [NFLAG-1:0] cond_i,
  input logic             wr_en_i,
  input logic             sel_i,
  input logic [NFLAG-1:0] wdata_i,
  input logic [NFLAG-1:0] flags,
  input logic             irq_o
);
  logic [NFLAG-1:0] clr_mask;
  assign clr_mask = (wr_en_i && !sel_i) ? wdata_i : '0;

  AST_COND_HOLDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    !soft_clr_i |=> (($past(cond_i) & ~flags) == '0)); // R5

  AST_SOFT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    soft_clr_i |=> (flags == '0)); // R8

  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    !soft_clr_i |=> ((($past(flags) & ~flags) & ~$past(clr_mask)) == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (((flags & ~$past(flags)) & ~$past(cond_i)) == '0)); // R2

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (flags != '0)); // R7
endmodule

bind can_rx_flag_reg can_rx_flag_reg_chk #(.NFLAG(NFLAG)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .soft_clr_i(soft_clr_i),
  .cond_i    (cond_i),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .flags     (flag_q),
  .irq_o     (irq_o)
);

// File: tb/sim_can_rx_flag_reg.sv
module sim_can_rx_flag_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic       soft_clr_i;
  logic [7:0] cond_i;
  logic       wr_en_i;
  logic       sel_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  can_rx_flag_reg u0 (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .soft_clr_i(soft_clr_i), .cond_i(cond_i),
    .wr_en_i(wr_en_i), .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {soft, cond[8], wr, sel, wdata[8], exp_flags[8], exp_irq}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h81, 1'b0, 1'b0, 8'h00, 8'h81, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 8'h81, 1'b1},
    {1'b0, 8'h01, 1'b1, 1'b0, 8'h81, 8'h01, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h01, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0},
    {1'b0, 8'h24, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h04, 8'h24, 1'b1},
    {1'b0, 8'h04, 1'b1, 1'b0, 8'h24, 8'h04, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0},
    {1'b1, 8'h42, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hFF, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h5A, 8'hA5, 1'b1}
  };

  function automatic string req_of(int i);
    case (i)
      0:       return "R1";
      1:       return "R2";
      2:       return "R6";
      3:       return "R5";
      4:       return "R4";
      5:       return "R3";
      6:       return "R1";
      7:       return "R7";
      8:       return "R5";
      9:       return "R3";
      10:      return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(logic s, output logic [7:0] v);
    sel_i = s;
    wr_en_i = 1'b0;
    #1;
    v = rdata_o;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    rst_n_i = 1'b0; soft_clr_i = 1'b0; cond_i = '0;
    wr_en_i = 1'b0; sel_i = 1'b0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R9: state after reset release
    read_reg(1'b0, v); check("R9", "flags after reset", v, 8'h00);
    read_reg(1'b1, v); check("R9", "mask after reset", v, 8'h00);
    check("R9", "irq after reset", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {soft_clr_i, cond_i, wr_en_i, sel_i, wdata_i} = VEC[i][27:9];
      @(posedge clk_i);
      @(negedge clk_i);
      soft_clr_i = 1'b0;
      read_reg(1'b0, v);
      check(req_of(i), $sformatf("vector %0d flags", i), v, VEC[i][8:1]);
      check("R7", $sformatf("vector %0d irq", i), {7'd0, irq_o}, {7'd0, VEC[i][0]});
    end
    // Flags now A5 with cond 00; mask FF

    // R1: bus-off is bit 2, overrun is bit 1, wake-up is bit 7
    @(negedge clk_i);
    cond_i = '0; wr_en_i = 1'b1; sel_i = 1'b0; wdata_i = 8'hFF;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    cond_i = 8'h86;
    @(negedge clk_i);
    cond_i = '0;
    read_reg(1'b0, v); check("R1", "wake bus-off overrun bits", v, 8'h86);

    // R10: repeated reads give the same value for both registers
    read_reg(1'b0, v);
    @(negedge clk_i);
    read_reg(1'b0, v2); check("R10", "flags reread", v2, v);
    read_reg(1'b1, v);
    @(negedge clk_i);
    read_reg(1'b1, v2); check("R10", "mask reread", v2, 8'hFF);

    // R8: soft clear keeps the mask while clearing the flags
    soft_clr_i = 1'b1; cond_i = 8'h10;
    @(negedge clk_i);
    soft_clr_i = 1'b0; cond_i = '0;
    read_reg(1'b0, v); check("R8", "flags after soft clear", v, 8'h00);
    read_reg(1'b1, v); check("R8", "mask kept across soft clear", v, 8'hFF);

    // R9: hard reset clears flags and mask before any clock edge
    cond_i = 8'h18;
    @(negedge clk_i);
    cond_i = '0;
    #2;
    rst_n_i = 1'b0;
    #1;
    read_reg(1'b0, v); check("R9", "flags on async reset", v, 8'h00);
    read_reg(1'b1, v); check("R9", "mask on async reset", v, 8'h00);
    check("R9", "irq on async reset", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (3) @(negedge clk_i);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule